// File: doc/BRIEF.md
# Bus Trace Word Capture Register

This block builds one 64-bit trace word for every memory reference on a watched bus and hands it to a downstream recorder together with a one-clock `rec_o` pulse. A trace word holds the 24-bit reference address, the 16-bit data value, a 16-bit event counter and eight auxiliary processor signals. The address, the auxiliary lines and the counter are sampled when the header strobe `hdr_stb` is seen. The data value is sampled later, when the data strobe `dat_stb` is seen. The reference is complete when its data strobe arrives. The word shown on `record_o` changes only when a reference completes, so the recorder never sees a half-built word.

Recording is gated by `run`. While `run` is low, strobes are ignored and `rec_o` stays low. A reference whose header arrived while running is dropped if `run` falls before its data strobe arrives. The counter has two modes. In reference mode it counts recorded references, so the recorder can spot a missing word. In gap mode it counts clock cycles and is cleared by each recorded reference, so the value in each word measures the idle time since the previous one.

Top module: `trace_capture`

## Requirements
- R1: A synchronous active-high `rst` clears `record_o` to 0, `rec_o` to 0, the pending reference and the counter to 0.
- R2: Field positions in `record_o`: address in bits 23:0, data in bits 39:24, counter in bits 55:40, auxiliary in bits 63:56.
- R3: The address, auxiliary and counter fields take their values from the cycle in which `hdr_stb` is sampled. The data field takes its value from the cycle in which `dat_stb` is sampled. Input changes at other times do not alter the word.
- R4: A reference completes on the clock edge that samples `dat_stb` while `run` is high and a header is pending. On that edge `rec_o` rises for exactly one clock and `record_o` takes the new word. At all other times `record_o` holds its value.
- R5: While `run` is low, both strobes are ignored, `rec_o` stays low and `record_o` holds. A pending header is discarded when `run` is sampled low.
- R6: A `dat_stb` with no pending header and no `hdr_stb` in the same cycle is ignored.
- R7: `hdr_stb` and `dat_stb` sampled in the same cycle, while `run` is high, form one complete reference.
- R8: With `cnt_mode`=0 (reference mode), the counter advances by one, modulo 2^16, on each completed reference and is otherwise unchanged. The first word after reset carries 0.
- R9: With `cnt_mode`=1 (gap mode), the counter advances by one on every clock and is cleared to 0 by the edge that completes a reference. A word whose header is sampled k edges after the completing edge of the previous reference carries k-1.
- R10: In gap mode the counter stops at 16'hFFFF and does not wrap.
- R11: If a second `hdr_stb` comes before the data strobe, the newer header values replace the older ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Recording enable |
| cnt_mode | input | 1 | Counter mode: 0 counts references, 1 measures the gap in clocks |
| hdr_stb | input | 1 | Strobe that samples address, auxiliary and counter |
| dat_stb | input | 1 | Strobe that samples data and completes the reference |
| addr_i | input | 24 | Bus address |
| data_i | input | 16 | Bus data |
| aux_i | input | 8 | Auxiliary processor signals |
| rec_o | output | 1 | One-clock pulse for each recorded reference |
| record_o | output | 64 | Most recent completed trace word |

## Verification
Most internal faults show up on the ports within one reference. A stuck or wrongly cleared pending flag shows up as a missing or extra `rec_o` on the clock after a data strobe. A staging register loaded at the wrong time puts a later address or auxiliary value into the next word. Counter faults are seen in the counter field of the next word recorded. A missed increment or clear shifts that value by at least one. A counter that wraps shows a small number after a long idle stretch instead of 16'hFFFF.

// File: rtl/trace_cap_pkg.sv
package trace_cap_pkg;

    localparam int ADDR_W = 24;
    localparam int DATA_W = 16;
    localparam int CNT_W  = 16;
    localparam int AUX_W  = 8;
    localparam int WORD_W = ADDR_W + DATA_W + CNT_W + AUX_W;

    typedef enum logic {
        CNT_REFS = 1'b0,
        CNT_GAP  = 1'b1
    } cnt_mode_e;

    // Header fields staged at the header strobe
    typedef struct packed {
        logic [AUX_W-1:0]  aux;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
    } hdr_fields_t;

    // Packed so that the address lands in the low bits
    typedef struct packed {
        logic [AUX_W-1:0]  aux;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] data;
        logic [ADDR_W-1:0] addr;
    } trace_word_t;

    function automatic trace_word_t build_word(hdr_fields_t h, logic [DATA_W-1:0] d);
        trace_word_t w;
        w.aux  = h.aux;
        w.cnt  = h.cnt;
        w.data = d;
        w.addr = h.addr;
        return w;
    endfunction

    function automatic logic [CNT_W-1:0] sat_inc(logic [CNT_W-1:0] v);
        return (v == {CNT_W{1'b1}}) ? v : v + CNT_W'(1);
    endfunction

endpackage

// File: rtl/trace_ref_ctrl.sv
module trace_ref_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic hdr_stb,
    input  logic dat_stb,
    output logic hdr_take,
    output logic commit,
    output logic rec_o
);

    logic pending;

    assign hdr_take = run && hdr_stb;
    assign commit   = run && dat_stb && (pending || hdr_stb);

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            rec_o   <= 1'b0;
        end else begin
            rec_o <= commit;
            if (!run || dat_stb)
                pending <= 1'b0;
            else if (hdr_stb)
                pending <= 1'b1;
        end
    end

    // R5: no record pulse follows a cycle with recording disabled
    assert_idle_no_rec_R5: assert property (@(posedge clk) disable iff (rst)
        !run |=> !rec_o);

    // R6: a data strobe with nothing pending produces no pulse
    assert_orphan_data_R6: assert property (@(posedge clk) disable iff (rst)
        (dat_stb && !hdr_stb && !pending) |=> !rec_o);

    // R4: once the data strobe is taken, nothing remains pending
    assert_pending_clear_R4: assert property (@(posedge clk) disable iff (rst)
        commit |=> !pending);

endmodule

// File: rtl/trace_evt_counter.sv
module trace_evt_counter
    import trace_cap_pkg::*;
#(
    parameter bit GAP_SATURATE = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_mode_e        mode,
    input  logic             commit,
    output logic [CNT_W-1:0] cnt
);

    logic [CNT_W-1:0] gap_next;

    generate
        if (GAP_SATURATE) begin : g_sat
            assign gap_next = sat_inc(cnt);
        end else begin : g_wrap
            assign gap_next = cnt + CNT_W'(1);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            unique case (mode)
                CNT_REFS: if (commit) cnt <= cnt + CNT_W'(1);
                CNT_GAP:  cnt <= commit ? '0 : gap_next;
                default:  cnt <= cnt;
            endcase
        end
    end

    // R8: reference mode only moves on a completed reference
    assert_refs_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (mode == CNT_REFS && !commit) |=> $stable(cnt));

    // R9: gap mode restarts from zero after a completed reference
    assert_gap_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (mode == CNT_GAP && commit) |=> (cnt == '0));

    // R10: gap mode holds at the top value
    assert_gap_saturate_R10: assert property (@(posedge clk) disable iff (rst)
        (mode == CNT_GAP && !commit && cnt == {CNT_W{1'b1}}) |=> (cnt == {CNT_W{1'b1}}));

endmodule

// File: rtl/trace_field_latch.sv
module trace_field_latch
    import trace_cap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hdr_take,
    input  logic              commit,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [AUX_W-1:0]  aux_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output trace_word_t       word_o
);

    hdr_fields_t staged;
    hdr_fields_t live;
    hdr_fields_t hdr_sel;

    always_comb begin
        live.aux  = aux_i;
        live.cnt  = cnt_i;
        live.addr = addr_i;
        hdr_sel   = hdr_take ? live : staged;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            staged <= '0;
            word_o <= '0;
        end else begin
            if (hdr_take)
                staged <= live;
            if (commit)
                word_o <= build_word(hdr_sel, data_i);
        end
    end

    // R4: the published word moves only when a reference completes
    assert_word_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(word_o));

    // R3: data field follows the bus value present at the data strobe
    assert_data_sample_R3: assert property (@(posedge clk) disable iff (rst)
        commit |=> (word_o.data == $past(data_i)));

endmodule

// File: rtl/trace_capture.sv
module trace_capture
    import trace_cap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              cnt_mode,
    input  logic              hdr_stb,
    input  logic              dat_stb,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [AUX_W-1:0]  aux_i,
    output logic              rec_o,
    output logic [WORD_W-1:0] record_o
);

    logic        hdr_take;
    logic        commit;
    logic [CNT_W-1:0] cnt;
    trace_word_t word;
    cnt_mode_e   mode;

    assign mode     = cnt_mode_e'(cnt_mode);
    assign record_o = word;

    trace_ref_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .hdr_stb  (hdr_stb),
        .dat_stb  (dat_stb),
        .hdr_take (hdr_take),
        .commit   (commit),
        .rec_o    (rec_o)
    );

    trace_evt_counter #(.GAP_SATURATE(1'b1)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode),
        .commit (commit),
        .cnt    (cnt)
    );

    trace_field_latch u_latch (
        .clk      (clk),
        .rst      (rst),
        .hdr_take (hdr_take),
        .commit   (commit),
        .addr_i   (addr_i),
        .data_i   (data_i),
        .aux_i    (aux_i),
        .cnt_i    (cnt),
        .word_o   (word)
    );

    // R1: reset leaves no pulse behind
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> !rec_o);

endmodule

// File: tb/trace_capture_test.sv
module trace_capture_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        run;
    logic        cnt_mode;
    logic        hdr_stb;
    logic        dat_stb;
    logic [23:0] addr_i;
    logic [15:0] data_i;
    logic [7:0]  aux_i;
    logic        rec_o;
    logic [63:0] record_o;

    int n_checks = 0;
    int n_fails  = 0;
    int n_done   = 0;
    logic [63:0] last_word = '0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    trace_capture uut (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .cnt_mode (cnt_mode),
        .hdr_stb  (hdr_stb),
        .dat_stb  (dat_stb),
        .addr_i   (addr_i),
        .data_i   (data_i),
        .aux_i    (aux_i),
        .rec_o    (rec_o),
        .record_o (record_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(logic [23:0] a, logic [15:0] d, logic [15:0] c, logic [7:0] x);
        // R2 layout: aux 63:56, counter 55:40, data 39:24, address 23:0
        return {x, c, d, a};
    endfunction

    // One reference: header, gap cycles, data; checks pulse and word.
    task automatic do_ref(input string req, input logic [23:0] a, input logic [15:0] d,
                          input logic [7:0] x, input int gap, input logic [15:0] exp_cnt);
        logic [63:0] exp;
        exp = mk(a, d, exp_cnt, x);
        hdr_stb = 1'b1; addr_i = a; aux_i = x;
        if (gap == 0) begin
            dat_stb = 1'b1; data_i = d;
        end
        @(negedge clk);
        hdr_stb = 1'b0; addr_i = ~a; aux_i = ~x;
        if (gap != 0) begin
            for (int i = 1; i < gap; i++) begin
                check({req, " no early rec"}, 64'(rec_o), 64'd0);
                @(negedge clk);
            end
            dat_stb = 1'b1; data_i = d;
            @(negedge clk);
        end
        dat_stb = 1'b0; data_i = ~d;
        check({req, " rec high"}, 64'(rec_o), 64'd1);
        check({req, " word"}, record_o, exp);
        @(negedge clk);
        check({req, " rec one clock"}, 64'(rec_o), 64'd0);
        check({req, " word held"}, record_o, exp);
        last_word = exp;
        n_done++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1'b1; run = 1'b0; cnt_mode = 1'b0;
        hdr_stb = 1'b0; dat_stb = 1'b0;
        addr_i = 24'h5A5A5A; data_i = 16'hA5A5; aux_i = 8'hC3;
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        check("R1 rec after reset", 64'(rec_o), 64'd0);
        check("R1 word after reset", record_o, 64'd0);
        run = 1'b1;
    endtask

    task automatic t_refs_mode;
        // R1 R8: first word carries 0, then counts completed references
        do_ref("R8 first", 24'h123456, 16'hBEEF, 8'h81, 2, 16'd0);
        do_ref("R8 second", 24'hABCDEF, 16'h1234, 8'h7E, 1, 16'd1);
        // R2 R3: spread fields, inputs scrambled after each strobe
        do_ref("R2 R3 layout", 24'hFFFFFF, 16'h0000, 8'hFF, 4, 16'd2);
        do_ref("R3 zeros", 24'h000000, 16'hFFFF, 8'h00, 3, 16'd3);
        // R7: both strobes in the same cycle
        do_ref("R7 same cycle", 24'h0F0F0F, 16'hF0F0, 8'h3C, 0, 16'd4);
        do_ref("R7 back to back", 24'h111111, 16'h2222, 8'h33, 0, 16'd5);
    endtask

    task automatic t_run_off;
        run = 1'b0;
        hdr_stb = 1'b1; addr_i = 24'hDEAD00; aux_i = 8'h11;
        @(negedge clk);
        hdr_stb = 1'b0; dat_stb = 1'b1; data_i = 16'h9999;
        @(negedge clk);
        dat_stb = 1'b0;
        check("R5 no rec while stopped", 64'(rec_o), 64'd0);
        @(negedge clk);
        check("R5 no rec while stopped late", 64'(rec_o), 64'd0);
        check("R5 word held while stopped", record_o, last_word);
        run = 1'b1;
        // R5 R8: counter was not advanced
        do_ref("R5 R8 after stop", 24'h000001, 16'h0002, 8'h03, 1, 16'(n_done));
    endtask

    task automatic t_abort;
        // header while running, then stop before data
        hdr_stb = 1'b1; addr_i = 24'h777777; aux_i = 8'h77;
        @(negedge clk);
        hdr_stb = 1'b0; run = 1'b0;
        @(negedge clk);
        run = 1'b1;
        dat_stb = 1'b1; data_i = 16'h7777;
        @(negedge clk);
        dat_stb = 1'b0;
        check("R5 dropped reference", 64'(rec_o), 64'd0);
        // R6: lone data strobe
        dat_stb = 1'b1; data_i = 16'h6666;
        @(negedge clk);
        dat_stb = 1'b0;
        check("R6 orphan data no rec", 64'(rec_o), 64'd0);
        check("R6 word unchanged", record_o, last_word);
        @(negedge clk);
        check("R6 still no rec", 64'(rec_o), 64'd0);
    endtask

    task automatic t_rehdr;
        logic [63:0] exp;
        exp = mk(24'h222222, 16'h4444, 16'(n_done), 8'h22);
        hdr_stb = 1'b1; addr_i = 24'h999999; aux_i = 8'h99;
        @(negedge clk);
        addr_i = 24'h222222; aux_i = 8'h22;
        @(negedge clk);
        hdr_stb = 1'b0; addr_i = '0; aux_i = '0;
        dat_stb = 1'b1; data_i = 16'h4444;
        @(negedge clk);
        dat_stb = 1'b0;
        check("R11 rec", 64'(rec_o), 64'd1);
        check("R11 newest header", record_o, exp);
        @(negedge clk);
        last_word = exp;
        n_done++;
    endtask

    task automatic t_gap_mode;
        cnt_mode = 1'b1;
        // prime: counter value unknown until a reference clears it
        do_ref("R9 prime", 24'h000010, 16'h0010, 8'h10, 1, 16'(0)) ;
    endtask

    task automatic t_gap_values;
        // header k edges after completion carries k-1; task tail adds one edge
        do_ref("R9 gap 0", 24'h000020, 16'h0020, 8'h20, 2, 16'd1);
        idle(5);
        do_ref("R9 gap 5", 24'h000030, 16'h0030, 8'h30, 1, 16'd6);
        idle(70000);
        do_ref("R10 saturate", 24'h000040, 16'h0040, 8'h40, 1, 16'hFFFF);
        do_ref("R10 R9 cleared after saturate", 24'h000050, 16'h0050, 8'h50, 3, 16'd1);
    endtask

    initial begin
        t_reset();
        t_refs_mode();
        t_run_off();
        t_abort();
        t_rehdr();
        t_gap_prime();
        t_gap_values();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // prime in gap mode: value before clear is not known, so check pulse only
    task automatic t_gap_prime;
        cnt_mode = 1'b1;
        hdr_stb = 1'b1; addr_i = 24'h000010; aux_i = 8'h10;
        dat_stb = 1'b1; data_i = 16'h0010;
        @(negedge clk);
        hdr_stb = 1'b0; dat_stb = 1'b0;
        check("R9 prime rec", 64'(rec_o), 64'd1);
        @(negedge clk);
        last_word = record_o;
        n_done++;
    endtask

    initial begin
        #1_900_000;
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule